// File: doc/BRIEF.md
# Split-Carry Phase Accumulator Oscillator

This block is a numerically controlled oscillator. Each clock it adds a 32-bit frequency word to a phase register that wraps modulo 2^32. The most significant phase bit is a square-wave clock whose average frequency is the clock rate times the word divided by 2^32. A wide adder in one feedback loop limits the clock rate, so the phase register is cut into equal segments (two 16-bit halves by default). The carry out of each segment is registered and feeds the next segment one clock later.

To make this work, the slice of the frequency word that drives segment k is delayed k clocks, so it meets the registered carry. Each segment's sum is delayed until the most significant segment catches up. Each segment closes its own feedback loop with no register inside it. The phase word seen at the output is therefore exactly the running sum a plain one-stage accumulator would give, with a fixed latency.

A new frequency word is first captured in a holding register. Its low half then enters the low segment one clock before its high half enters the high segment. A word change therefore lands as one whole step at the output, with no glitch.

Top module: `nco_split_acc`

## Requirements
- R1: Reset is synchronous and active high. After any rising edge with `rst_i` high, `phase_o` reads 0 and `clk_o` reads 0, and they stay there while reset is held.
- R2: Once three clean edges have passed since reset, the value of `phase_o` after an edge minus its value after the previous edge equals, modulo 2^32, the `freq_i` value sampled three edges earlier. Put another way, the word sampled at edge n is first part of `phase_o` after edge n+2.
- R3: Carries between segments are neither lost nor doubled. Words such as 0x0000_FFFF and 0x0000_0001 give the exact running sum as the low segment wraps.
- R4: The sum wraps modulo 2^32 and the carry out of the top segment is dropped. A word of 0xFFFF_FFFF lowers `phase_o` by exactly one per clock.
- R5: A word of zero, once it is in effect, leaves `phase_o` unchanged from clock to clock.
- R6: `clk_o` always equals bit 31 of `phase_o`.
- R7: When `freq_i` changes at arbitrary edges, every sampled word adds into the phase exactly once, as a single whole-word step in the R2 cycle.
- R8: A word of 906,238,099 (about 0.211 of the clock rate) gives `clk_o` rising edges spaced only 4 or 5 clocks apart, with both spacings occurring.
- R9: A word of 0x8000_0000 makes `clk_o` change level on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for all registers |
| rst_i | input | 1 | Synchronous active-high reset; clears every register |
| freq_i | input | 32 | Frequency word added to the phase each clock |
| phase_o | output | 32 | Realigned phase word |
| clk_o | output | 1 | Square-wave output, the phase MSB |

## Verification
The assertions assume that `freq_i` and `rst_i` are stable around each rising edge. They also assume the running-sum relation only after three edges with reset low, because the holding, skew and deskew registers need that long to fill with real data. The segment wrap checks likewise wait one clean edge after reset. The stimulus changes inputs only on the falling clock edge and holds reset for several clocks, both at the start and again in mid-run. Random words are mixed with directed all-ones, zero, carry-boundary, half-scale and 0.211-ratio words.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int NCO_PHASE_W = 32;
    localparam int NCO_SEG_W   = 16;

    // Number of carry-split segments in a phase word.
    function automatic int nco_seg_count(input int phase_w, input int seg_w);
        return phase_w / seg_w;
    endfunction

endpackage

// File: rtl/nco_delay_line.sv
// Fixed-depth register chain with synchronous clear.
module nco_delay_line #(
    parameter int W     = 16,
    parameter int DEPTH = 1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q_o = stage_q[DEPTH-1];

endmodule

// File: rtl/nco_seg_acc.sv
// One accumulator segment: sum feeds straight back; carry out is registered.
module nco_seg_acc #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] addend_i,
    input  logic         cin_i,
    output logic [W-1:0] acc_o,
    output logic         cout_o
);

    logic [W-1:0] acc_q;
    logic         cy_q;
    logic [W:0]   sum_ext;

    always_comb begin
        sum_ext = {1'b0, acc_q} + {1'b0, addend_i} + {{W{1'b0}}, cin_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q <= '0;
            cy_q  <= 1'b0;
        end else begin
            acc_q <= sum_ext[W-1:0];
            cy_q  <= sum_ext[W];
        end
    end

    assign acc_o  = acc_q;
    assign cout_o = cy_q;

endmodule

// File: rtl/nco_split_acc.sv
// Carry-split phase accumulator oscillator.
module nco_split_acc
    import nco_pkg::*;
#(
    parameter int PHASE_W = NCO_PHASE_W,
    parameter int SEG_W   = NCO_SEG_W
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [PHASE_W-1:0] freq_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               clk_o
);

    localparam int SEGS = nco_seg_count(PHASE_W, SEG_W);

    logic [PHASE_W-1:0] freq_q;
    logic [SEG_W-1:0]   seg_add  [SEGS];
    logic [SEG_W-1:0]   seg_acc  [SEGS];
    logic [SEG_W-1:0]   seg_out  [SEGS];
    logic               seg_cin  [SEGS];
    logic               seg_cout [SEGS];

    // Holding register: a new word enters the pipeline as one unit.
    nco_delay_line #(.W(PHASE_W), .DEPTH(1)) u_hold (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (freq_i),
        .q_o   (freq_q)
    );

    for (genvar k = 0; k < SEGS; k++) begin : g_seg
        // Addend skew: segment k waits k clocks for its carry.
        if (k == 0) begin : g_add_direct
            assign seg_add[k] = freq_q[k*SEG_W +: SEG_W];
            assign seg_cin[k] = 1'b0;
        end else begin : g_add_skew
            nco_delay_line #(.W(SEG_W), .DEPTH(k)) u_add_skew (
                .clk_i (clk_i),
                .rst_i (rst_i),
                .d_i   (freq_q[k*SEG_W +: SEG_W]),
                .q_o   (seg_add[k])
            );
            assign seg_cin[k] = seg_cout[k-1];
        end

        nco_seg_acc #(.W(SEG_W)) u_seg (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .addend_i (seg_add[k]),
            .cin_i    (seg_cin[k]),
            .acc_o    (seg_acc[k]),
            .cout_o   (seg_cout[k])
        );

        // Output deskew: lower segments wait for the top one.
        if (k == SEGS - 1) begin : g_out_direct
            assign seg_out[k] = seg_acc[k];
        end else begin : g_out_skew
            nco_delay_line #(.W(SEG_W), .DEPTH(SEGS - 1 - k)) u_out_skew (
                .clk_i (clk_i),
                .rst_i (rst_i),
                .d_i   (seg_acc[k]),
                .q_o   (seg_out[k])
            );
        end
    end

    always_comb begin
        phase_o = '0;
        for (int k = 0; k < SEGS; k++) begin
            phase_o[k*SEG_W +: SEG_W] = seg_out[k];
        end
    end

    assign clk_o = phase_o[PHASE_W-1];

endmodule

// File: rtl/nco_split_acc_chk.sv
// Property checker for the split-carry accumulator.
module nco_split_acc_chk #(
    parameter int PHASE_W = 32,
    parameter int SEG_W   = 16
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic [PHASE_W-1:0] freq_i,
    input logic [PHASE_W-1:0] phase_o,
    input logic               clk_o,
    input logic [SEG_W-1:0]   lo_acc_i,
    input logic               lo_cy_i,
    input logic [SEG_W-1:0]   hi_acc_i,
    input logic               hi_cy_i
);

    logic [1:0] live_cnt;
    logic       past_rst_q;

    always_ff @(posedge clk_i) begin
        past_rst_q <= rst_i;
        if (rst_i) begin
            live_cnt <= '0;
        end else if (live_cnt != 2'd3) begin
            live_cnt <= live_cnt + 2'd1;
        end
    end

    // R1
    always @(posedge clk_i) begin
        if (past_rst_q === 1'b1) begin
            reset_clear_chk: assert (phase_o == '0 && clk_o == 1'b0);
        end
    end

    // R2
    running_sum_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_cnt == 2'd3) |-> ((phase_o - $past(phase_o)) == $past(freq_i, 3)));

    // R3
    low_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_cnt != 2'd0 && lo_cy_i) |-> (lo_acc_i <= $past(lo_acc_i)));

    // R3
    low_nowrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_cnt != 2'd0 && !lo_cy_i) |-> (lo_acc_i >= $past(lo_acc_i)));

    // R4
    top_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_cnt != 2'd0 && hi_cy_i) |-> (hi_acc_i <= $past(hi_acc_i)));

    // R4
    top_nowrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_cnt != 2'd0 && !hi_cy_i) |-> (hi_acc_i >= $past(hi_acc_i)));

endmodule

bind nco_split_acc nco_split_acc_chk #(
    .PHASE_W (PHASE_W),
    .SEG_W   (SEG_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .freq_i   (freq_i),
    .phase_o  (phase_o),
    .clk_o    (clk_o),
    .lo_acc_i (seg_acc[0]),
    .lo_cy_i  (seg_cout[0]),
    .hi_acc_i (seg_acc[SEGS-1]),
    .hi_cy_i  (seg_cout[SEGS-1])
);

// File: tb/test_nco_split_acc.sv
module test_nco_split_acc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] freq = '0;
    logic [31:0] phase_o;
    logic        clk_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] r_hold, r_acc, r_out;
    logic [31:0] last_ph;

    // 50 MHz: 20 time-unit period
    always #10 clk = ~clk;

    nco_split_acc i_nco_split_acc (
        .clk_i   (clk),
        .rst_i   (rst),
        .freq_i  (freq),
        .phase_o (phase_o),
        .clk_o   (clk_o)
    );

    // Plain full-width accumulator reference, aligned to the stated latency (R2)
    always @(posedge clk) begin
        if (rst) begin
            r_hold <= '0;
            r_acc  <= '0;
            r_out  <= '0;
        end else begin
            r_hold <= freq;
            r_acc  <= r_acc + r_hold;
            r_out  <= r_acc;
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sample at the falling edge, compare, then drive the next word.
    task automatic step(input logic [31:0] w, input string req);
        @(negedge clk);
        chk(phase_o == r_out, req, phase_o, r_out);
        chk(clk_o == phase_o[31], "R6", {31'd0, clk_o}, {31'd0, phase_o[31]});
        last_ph = phase_o;
        freq = w;
    endtask

    initial begin
        int gap;
        int n4;
        int n5;
        bit seen;
        bit prev_clk;
        void'($urandom(32'd20041207));

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(phase_o == '0 && clk_o == 1'b0, "R1", phase_o, 32'd0);
        end
        rst = 1'b0;

        // R3: words that make the low segment carry often
        for (int i = 0; i < 40; i++) step(32'h0000_FFFF, "R3");
        for (int i = 0; i < 20; i++) step(32'h0000_0001, "R3");
        for (int i = 0; i < 20; i++) step(32'h0001_FFFF, "R3");

        // R4: all ones lowers the phase by one each clock
        for (int i = 0; i < 6; i++) step(32'hFFFF_FFFF, "R4");
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(phase_o - last_ph == 32'hFFFF_FFFF, "R4", phase_o - last_ph, 32'hFFFF_FFFF);
            last_ph = phase_o;
        end

        // R5: zero word holds the phase
        for (int i = 0; i < 4; i++) step(32'h0000_0000, "R5");
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(phase_o == last_ph, "R5", phase_o, last_ph);
            last_ph = phase_o;
        end

        // R9: half-scale word toggles the output clock every cycle
        for (int i = 0; i < 4; i++) step(32'h8000_0000, "R9");
        prev_clk = clk_o;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(clk_o != prev_clk, "R9", {31'd0, clk_o}, {31'd0, ~prev_clk});
            prev_clk = clk_o;
        end

        // R8: 0.211 ratio gives 4- and 5-clock output periods
        for (int i = 0; i < 6; i++) step(32'd906238099, "R8");
        gap = 0; n4 = 0; n5 = 0; seen = 1'b0;
        prev_clk = clk_o;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            gap++;
            if (clk_o && !prev_clk) begin
                if (seen) begin
                    chk(gap == 4 || gap == 5, "R8", gap, 32'd4);
                    if (gap == 4) n4++;
                    if (gap == 5) n5++;
                end
                gap = 0;
                seen = 1'b1;
            end
            prev_clk = clk_o;
        end
        chk(n4 > 0 && n5 > 0, "R8", n4, n5);

        // R7: random words that change at irregular edges
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            int hold;
            w = $urandom();
            hold = int'($urandom_range(1, 4));
            for (int j = 0; j < hold; j++) step(w, "R7");
        end
        step(32'hFFFF_FFFF, "R7");
        step(32'h0000_0000, "R7");
        step(32'hFFFF_FFFF, "R7");
        for (int i = 0; i < 5; i++) step(32'h0000_0000, "R7");

        // R1: reset in mid-run
        for (int i = 0; i < 10; i++) step(32'h1234_5679, "R2");
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(phase_o == '0 && clk_o == 1'b0, "R1", phase_o, 32'd0);
        end
        rst = 1'b0;

        // R2: running sum after a fresh reset
        for (int i = 0; i < 200; i++) step($urandom(), "R2");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule